// File: doc/BRIEF.md
# Indirect Core Register Access Bridge

This block gives a host two byte-wide registers through which it can reach up to 64 registers inside a slower core. A control register selects the target and carries two flags: an auto-read enable and a busy flag. A data register carries the value. A write to the data register is forwarded to the selected core register. A read of a core register is split-phase. The host sets the busy flag, and the bridge then issues a request on the core side. When the acknowledge returns, the bridge latches the returned value into the data register and drops the busy flag.

With auto-read enabled, every host read of the data register returns the value already latched. In the same cycle it starts a fresh fetch from the same core address. A FIFO-like core location can therefore be drained by a run of data reads, with only a busy poll between them. The core port allows one transaction at a time. Each transaction is a single-cycle request with address and direction, ended by an acknowledge that may come any number of cycles later.

Top module: `ireg_bridge`

## Requirements
- R1: The control register reads back as {busy in bit 7, auto-read enable in bit 6, core address in bits 5..0}. A control write loads bit 6 and bits 5..0 as written.
- R2: After reset the control register reads 0x00, the error flag is 0 and no core request is issued.
- R3: A control write with bit 7 = 1, made while no core transaction is outstanding, causes exactly one core read request (core_we = 0) in the next cycle. A control write with bit 7 = 0 causes no request. core_req is high for one cycle only.
- R4: When the address and bit 7 are set in one control write, the resulting core read uses the newly written address.
- R5: The busy flag reads 1 from the cycle after a read is started until the acknowledge is taken. At that edge the data register captures core_rdata and busy clears.
- R6: With auto-read at 1, a host read of the data register made while idle starts a new core read of the unchanged address. Successive reads therefore return successive core values in order, and the address field keeps its value.
- R7: With auto-read at 0, host reads of the data register issue no core request.
- R8: A host write to the data register while idle issues, in the next cycle, a core write request (core_we = 1) carrying the written byte and the current address.
- R9: A host write to the data register while a core transaction is outstanding is dropped: no request is made and the core register is unchanged. It also sets the sticky err output, which stays 1 until reset.
- R10: A bit-7 control write while a core transaction is outstanding does not start another request, so only one request is ever outstanding.
- R11: host_rdata is registered. It shows the selected register, sampled before that edge's updates, in the cycle after a host read strobe, and it holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host register select: 0 control, 1 data |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle, never with host_wr |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| core_req | output | 1 | Core request pulse |
| core_we | output | 1 | Core request direction, 1 = write |
| core_addr | output | 6 | Core register address |
| core_wdata | output | 8 | Core write data |
| core_ack | input | 1 | Core acknowledge, ends the outstanding request |
| core_rdata | input | 8 | Core read data, valid with core_ack |
| err | output | 1 | Sticky flag for a data write dropped while busy |

## Verification
The assertions watch every cycle for several properties. They check that core requests are single-cycle and never overlap an outstanding one. They check that an idle data write always turns into a core write of the same byte. They also check that the error flag never falls and that host_rdata moves only after a read strobe. Other behaviour can only be shown by the bench's scenarios against its core model. This covers the order of values drained from the FIFO location in auto-read mode, and the absence of fetches with auto-read off. It also covers the final contents of a core register after an accepted or a dropped write, and the busy flag seen through control reads.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
  // host register select encoding
  typedef enum logic [0:0] {
    SEL_CTRL = 1'b0,
    SEL_DATA = 1'b1
  } host_sel_e;
endpackage

// File: rtl/ireg_host_regs.sv
module ireg_host_regs
  import ireg_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          pending,
  input  logic          rd_done,
  input  logic [DW-1:0] rd_data,
  output logic          start_rd,
  output logic          start_wr,
  output logic [AW-1:0] tgt_addr,
  output logic          err
);
  localparam int AUTO_BIT = AW;
  localparam int BUSY_BIT = AW + 1;

  logic [AW-1:0] addr_q;
  logic          auto_q;
  logic          busy_q;
  logic [DW-1:0] data_q;
  logic          ctrl_wr, data_wr, ctrl_rd, data_rd;

  always_comb begin
    ctrl_wr  = host_wr && (host_sel == SEL_CTRL);
    data_wr  = host_wr && (host_sel == SEL_DATA);
    ctrl_rd  = host_rd && (host_sel == SEL_CTRL);
    data_rd  = host_rd && (host_sel == SEL_DATA);
    tgt_addr = ctrl_wr ? host_wdata[AW-1:0] : addr_q;
    start_rd = !pending && ((ctrl_wr && host_wdata[BUSY_BIT]) || (data_rd && auto_q));
    start_wr = !pending && data_wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q     <= '0;
      auto_q     <= 1'b0;
      busy_q     <= 1'b0;
      data_q     <= '0;
      err        <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (ctrl_wr) begin
        addr_q <= host_wdata[AW-1:0];
        auto_q <= host_wdata[AUTO_BIT];
      end
      if (start_rd)     busy_q <= 1'b1;
      else if (rd_done) busy_q <= 1'b0;
      if (rd_done) data_q <= rd_data;
      if (data_wr && pending) err <= 1'b1;
      if (ctrl_rd)      host_rdata <= DW'({busy_q, auto_q, addr_q});
      else if (data_rd) host_rdata <= data_q;
    end
  end
endmodule

// File: rtl/ireg_core_port.sv
module ireg_core_port #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_rd,
  input  logic          start_wr,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_wdata,
  output logic          pending,
  output logic          rd_done,
  output logic [DW-1:0] rd_data,
  output logic          core_req,
  output logic          core_we,
  output logic [AW-1:0] core_addr,
  output logic [DW-1:0] core_wdata,
  input  logic          core_ack,
  input  logic [DW-1:0] core_rdata
);
  logic is_rd_q;

  always_comb begin
    rd_done = core_ack && pending && is_rd_q;
    rd_data = core_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending    <= 1'b0;
      is_rd_q    <= 1'b0;
      core_req   <= 1'b0;
      core_we    <= 1'b0;
      core_addr  <= '0;
      core_wdata <= '0;
    end else begin
      core_req <= 1'b0;
      if (start_rd || start_wr) begin
        core_req   <= 1'b1;
        core_we    <= start_wr;
        core_addr  <= tgt_addr;
        core_wdata <= tgt_wdata;
        is_rd_q    <= start_rd;
        pending    <= 1'b1;
      end else if (core_ack && pending) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          core_req,
  output logic          core_we,
  output logic [AW-1:0] core_addr,
  output logic [DW-1:0] core_wdata,
  input  logic          core_ack,
  input  logic [DW-1:0] core_rdata,
  output logic          err
);
  logic          pending, rd_done, start_rd, start_wr;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] tgt_addr;

  ireg_host_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pending(pending), .rd_done(rd_done), .rd_data(rd_data),
    .start_rd(start_rd), .start_wr(start_wr), .tgt_addr(tgt_addr), .err(err)
  );

  ireg_core_port #(.AW(AW), .DW(DW)) u_port (
    .clk(clk), .rst(rst), .start_rd(start_rd), .start_wr(start_wr),
    .tgt_addr(tgt_addr), .tgt_wdata(host_wdata), .pending(pending),
    .rd_done(rd_done), .rd_data(rd_data), .core_req(core_req),
    .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_ack(core_ack), .core_rdata(core_rdata)
  );
endmodule

// File: rtl/ireg_bridge_chk.sv
module ireg_bridge_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          host_sel,
  input logic          host_wr,
  input logic          host_rd,
  input logic [DW-1:0] host_wdata,
  input logic [DW-1:0] host_rdata,
  input logic          core_req,
  input logic          core_we,
  input logic [DW-1:0] core_wdata,
  input logic          core_ack,
  input logic          err
);
  // outstanding transaction tracked from the core-side pins only
  logic pend_q;
  always_ff @(posedge clk) begin
    if (rst)           pend_q <= 1'b0;
    else if (core_ack) pend_q <= 1'b0;
    else if (core_req) pend_q <= 1'b1;
  end

  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    core_req |=> !core_req);

  assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (rst)
    core_req |-> !pend_q);

  assert_idle_write_forwarded_R8: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_sel && !core_req && !pend_q) |=>
      (core_req && core_we && core_wdata == $past(host_wdata)));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));
endmodule

bind ireg_bridge ireg_bridge_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
  .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .core_req(core_req), .core_we(core_we), .core_wdata(core_wdata),
  .core_ack(core_ack), .err(err)
);

// File: tb/ireg_bridge_bench.sv
`timescale 1ns/1ps
module ireg_bridge_bench;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam logic [5:0] FIFO_A = 6'h20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic core_req, core_we, err;
  logic [5:0] core_addr;
  logic [7:0] core_wdata;
  logic core_ack = 1'b0;
  logic [7:0] core_rdata = '0;

  int tests = 0, fails = 0;
  bit done = 0;
  int reqcnt = 0;

  always #5 clk = ~clk;

  ireg_bridge #(.AW(AW), .DW(DW)) u_ireg_bridge (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_ack(core_ack), .core_rdata(core_rdata),
    .err(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- core-side model: registers plus a FIFO location
  logic [7:0] mem [64];
  logic [7:0] fifo [$];
  int cnt = 0, seed = 0;

  always @(negedge clk) begin
    core_ack = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) core_ack = 1'b1;
    end
    if (!rst && core_req) begin
      reqcnt++;
      if (core_we) begin
        if (core_addr == FIFO_A) fifo.push_back(core_wdata);
        else mem[core_addr] = core_wdata;
      end else begin
        if (core_addr == FIFO_A) core_rdata = (fifo.size() > 0) ? fifo.pop_front() : 8'hEE;
        else core_rdata = mem[core_addr];
      end
      cnt = 1 + (seed % 4);
      seed++;
    end
  end

  // ---------------- behavioural reference, stepped each rising edge
  logic [5:0] m_addr;
  logic m_auto, m_busy, m_pend, m_isrd, m_err, m_req, m_we;
  logic [5:0] m_raddr;
  logic [7:0] m_data, m_rdata, m_wdata;

  always @(posedge clk) begin
    if (rst) begin
      m_addr = 0; m_auto = 0; m_busy = 0; m_pend = 0; m_isrd = 0; m_err = 0;
      m_req = 0; m_we = 0; m_raddr = 0; m_data = 0; m_rdata = 0; m_wdata = 0;
    end else begin
      bit was_pend, fetch, wr_go;
      was_pend = m_pend;
      if (host_rd && !host_sel) m_rdata = {m_busy, m_auto, m_addr};
      else if (host_rd && host_sel) m_rdata = m_data;
      if (core_ack && m_pend) begin
        m_pend = 0;
        if (m_isrd) begin m_data = core_rdata; m_busy = 0; end
      end
      if (host_wr && host_sel && was_pend) m_err = 1;
      fetch = !was_pend && ((host_wr && !host_sel && host_wdata[7]) ||
                            (host_rd && host_sel && m_auto));
      wr_go = !was_pend && host_wr && host_sel;
      if (host_wr && !host_sel) begin m_addr = host_wdata[5:0]; m_auto = host_wdata[6]; end
      m_req = fetch || wr_go;
      if (m_req) begin
        m_we = wr_go; m_raddr = m_addr; m_wdata = host_wdata;
        m_pend = 1; m_isrd = fetch;
        if (fetch) m_busy = 1;
      end
    end
  end

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(host_rdata == m_rdata, "R11 host_rdata", host_rdata, m_rdata);
      chk(core_req == m_req, "R3 core_req", core_req, m_req);
      chk(err == m_err, "R9 err", err, m_err);
      if (m_req) begin
        chk(core_addr == m_raddr, "R4 core_addr", core_addr, m_raddr);
        chk(core_we == m_we, "R8 core_we", core_we, m_we);
        if (m_we) chk(core_wdata == m_wdata, "R8 core_wdata", core_wdata, m_wdata);
      end
    end
  end

  // ---------------- host tasks
  task automatic hwr(input logic sel, input logic [7:0] v);
    @(negedge clk); host_wr = 1; host_sel = sel; host_wdata = v;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hrd(input logic sel, output logic [7:0] v);
    @(negedge clk); host_rd = 1; host_sel = sel;
    @(negedge clk); host_rd = 0; v = host_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] v;
    int n = 0;
    do begin hrd(0, v); n++; end while (v[7] && n < 50);
    chk(!v[7], tag, v, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int snap;
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R2 reset state
    hrd(0, v);
    chk(v == 8'h00, "R2 ctrl after reset", v, 0);
    chk(err == 0, "R2 err after reset", err, 0);
    chk(reqcnt == 0, "R2 no request after reset", reqcnt, 0);

    // R4/R5 address and busy in one write
    hwr(0, 8'h85);
    hrd(0, v);
    chk(v[7] == 1, "R5 busy set during fetch", v[7], 1);
    chk(v[5:0] == 6'h05, "R1 address field", v[5:0], 5);
    wait_idle("R5 busy clears");
    hrd(1, v);
    chk(v == mem[5], "R4 data from new address", v, mem[5]);

    // R3 bit 7 clear starts nothing
    snap = reqcnt;
    hwr(0, 8'h0A); idle(6);
    chk(reqcnt == snap, "R3 no fetch without busy bit", reqcnt, snap);
    hrd(0, v);
    chk(v == 8'h0A, "R1 ctrl readback", v, 8'h0A);

    // R8 data write forwarded
    hwr(1, 8'h5C); idle(6);
    chk(mem[10] == 8'h5C, "R8 core register written", mem[10], 8'h5C);
    hwr(0, 8'h8A); wait_idle("R5 busy clears after refetch");
    hrd(1, v);
    chk(v == 8'h5C, "R8 readback of written value", v, 8'h5C);

    // R9 write while busy dropped
    hwr(0, 8'h8B);
    hwr(1, 8'h77);
    chk(err == 1, "R9 err raised", err, 1);
    wait_idle("R5 busy clears");
    idle(6);
    chk(mem[11] == 8'(11 * 7 + 3), "R9 core register untouched", mem[11], 11 * 7 + 3);

    // R10 second busy write during fetch
    snap = reqcnt;
    hwr(0, 8'h8C); hwr(0, 8'h8C);
    wait_idle("R10 busy clears"); idle(6);
    chk(reqcnt == snap + 1, "R10 single request", reqcnt - snap, 1);

    // R6 auto-read drains the FIFO location in order
    hwr(0, 8'h20);
    for (int i = 0; i < 5; i++) begin hwr(1, 8'(8'h40 + i)); idle(6); end
    hwr(0, 8'hE0);
    wait_idle("R6 first fetch");
    for (int i = 0; i < 5; i++) begin
      hrd(1, v);
      chk(v == 8'(8'h40 + i), "R6 FIFO order", v, 8'h40 + i);
      wait_idle("R6 busy clears between reads");
    end
    hrd(0, v);
    chk(v == 8'h60, "R6 address and auto bit unchanged", v, 8'h60);
    hrd(1, v);
    chk(v == 8'hEE, "R6 fetch after last item", v, 8'hEE);
    wait_idle("R6 trailing fetch");

    // R7 auto-read off: data reads start nothing
    hwr(0, 8'h05); idle(6);
    snap = reqcnt;
    hrd(1, v); hrd(1, v); idle(6);
    chk(reqcnt == snap, "R7 no fetch with auto off", reqcnt, snap);

    // R11 read data holds while no strobe
    v = host_rdata; idle(4);
    chk(host_rdata == v, "R11 host_rdata holds", host_rdata, v);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule